// File: doc/BRIEF.md
# Dual Down-Counter Timer Block

This block places two identical down-counting timers behind one 4 KB register window on a simple request interface (valid, write flag, byte address, write data). The low part of the window holds the two timers' register sets, 32 bytes each. The top of the window holds eight read-only identification words, and two integration-test locations always read as zero. Every other location reads zero, and writes to it do nothing.

Each timer advances only on cycles where its own tick-enable input is high. This lets the surrounding logic run each timer at its own rate; both rates would normally be 1 MHz. Each timer drives its own interrupt line, and a third output raises whenever either line is high. Read data comes back one cycle after the request, marked by a one-cycle valid strobe.

Top module: `dual_tick_timer`

## Requirements
- R1: Byte offsets 0x000 to 0x01F reach timer 0, and bits [4:2] of the offset select its register.
- R2: Byte offsets 0x020 to 0x03F reach timer 1, with 0x20 removed, so the same register layout applies as for timer 0.
- R3: A read of offset 0xFE0 + 4*k (k = 0 to 7) returns the k-th of the bytes 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits [7:0], with the upper bits zero.
- R4: Reads of the test-control word at 0xF00 and the test-output word at 0xF04 return zero.
- R5: Writes to the identification region, the test words or any unmapped offset change no state. Reads of unmapped offsets return zero.
- R6: `irqAny` is high exactly when `irq0` or `irq1` is high.
- R7: Each timer counts only on cycles where its own tick input is high, and the other timer's tick has no effect on it.
- R8: A read request in cycle n gives `rdValid` high with the data in cycle n+1. `rdValid` is low after every other cycle.
- R9: After reset, the outputs `rdValid`, `irq0`, `irq1` and `irqAny` are low. Each timer's reload and count registers read 0, and its control register reads 0x4.
- R10: The timer registers are laid out as follows. Word 0 is the reload register; a write loads both the reload and count values. Word 1 is the count value and is read-only. Word 2 is control, with bit0 run, bit1 auto-reload and bit2 interrupt enable. A write of any value to word 3 clears the raw flag. Word 4 is the raw flag and word 5 is the raw flag ANDed with the interrupt enable. Words 6 and 7 read zero. On a tick while running, a count above zero decrements. A count of zero sets the raw flag and then either reloads (auto-reload) or clears run. An expiry in the same cycle as a clear leaves the flag set, and a reload write takes precedence over a tick.
- R11: Each timer's interrupt output equals its raw flag ANDed with its interrupt-enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 12 | Byte offset in the window |
| reqWdata | input | 32 | Write data |
| tick0 | input | 1 | Count enable for timer 0 |
| tick1 | input | 1 | Count enable for timer 1 |
| rdValid | output | 1 | Read data valid, one cycle after a read |
| rdData | output | 32 | Read data |
| irq0 | output | 1 | Timer 0 interrupt |
| irq1 | output | 1 | Timer 1 interrupt |
| irqAny | output | 1 | OR of both interrupts |

## Verification
The assertions assume that requests use word-aligned offsets and that the request inputs are stable around each rising edge. They also take a raw flag to be new only when a tick occurred at the previous edge. The stimulus issues only aligned addresses and changes inputs on falling edges. It holds ticks high or low in patterns chosen to reach expiry with and without auto-reload, and at the same time as clears and reload writes. A behavioural model in the bench predicts every output on every cycle.

// File: rtl/dtw_pkg.sv
package dtw_pkg;
  localparam int NTMR = 2;

  typedef struct packed {
    logic       rdStrobe;
    logic       tmrHit;
    logic       tmrIdx;
    logic [2:0] regSel;
    logic       tmrWr;
    logic       idHit;
    logic [2:0] idIdx;
  } dtwStrobe_t;

  function automatic logic [7:0] idByte(input logic [2:0] i);
    case (i)
      3'd0: idByte = 8'h04;
      3'd1: idByte = 8'h18;
      3'd2: idByte = 8'h14;
      3'd3: idByte = 8'h00;
      3'd4: idByte = 8'h0D;
      3'd5: idByte = 8'hF0;
      3'd6: idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/dtw_timer.sv
module dtw_timer #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic          wrEn,
  input  logic [2:0]    regSel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdWord,
  output logic          irq
);
  logic [DW-1:0] loadVal, count;
  logic run, autoLd, intEn, rawInt;
  logic wrLoad, wrCtrl, wrClr, expire;

  assign wrLoad = wrEn && (regSel == 3'd0);
  assign wrCtrl = wrEn && (regSel == 3'd2);
  assign wrClr  = wrEn && (regSel == 3'd3);
  assign expire = tick && run && (count == '0) && !wrLoad;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadVal <= '0;
      count   <= '0;
      run     <= 1'b0;
      autoLd  <= 1'b0;
      intEn   <= 1'b1;
      rawInt  <= 1'b0;
    end else begin
      if (wrLoad) begin
        loadVal <= wdata;
        count   <= wdata;
      end else if (tick && run) begin
        if (count == '0) begin
          if (autoLd) count <= loadVal;
        end else begin
          count <= count - 1'b1;
        end
      end
      if (wrCtrl) begin
        run    <= wdata[0];
        autoLd <= wdata[1];
        intEn  <= wdata[2];
      end else if (expire && !autoLd) begin
        run <= 1'b0;
      end
      if (expire)     rawInt <= 1'b1;
      else if (wrClr) rawInt <= 1'b0;
    end
  end

  always_comb begin
    rdWord = '0;
    case (regSel)
      3'd0: rdWord = loadVal;
      3'd1: rdWord = count;
      3'd2: rdWord = DW'({intEn, autoLd, run});
      3'd4: rdWord = DW'(rawInt);
      3'd5: rdWord = DW'(rawInt && intEn);
      default: rdWord = '0;
    endcase
  end

  assign irq = rawInt && intEn;

  // R10
  raw_needs_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rawInt) |-> $past(tick));
  // R10
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && run && !autoLd && count == '0 && !wrEn) |=> !run);
  // R7
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !wrEn) |=> $stable(count));
endmodule

// File: rtl/dtw_ctrl.sv
module dtw_ctrl
  import dtw_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic [AW-1:0] reqAddr,
  output dtwStrobe_t    st
);
  localparam logic [AW-1:0] TMR_END = AW'(12'h040);
  localparam logic [AW-1:0] ID_BASE = AW'(12'hFE0);

  always_comb begin
    st          = '0;
    st.rdStrobe = reqValid && !reqWrite;
    st.tmrHit   = reqAddr < TMR_END;
    st.tmrIdx   = reqAddr[5];
    st.regSel   = reqAddr[4:2];
    st.tmrWr    = reqValid && reqWrite && st.tmrHit;
    st.idHit    = reqAddr >= ID_BASE;
    st.idIdx    = reqAddr[4:2];
  end

  // R5
  high_write_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqAddr >= TMR_END) |-> !st.tmrWr);
  // R1
  region_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.tmrHit, st.idHit}));
endmodule

// File: rtl/dtw_datapath.sv
module dtw_datapath
  import dtw_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  dtwStrobe_t      st,
  input  logic [DW-1:0]   wdata,
  input  logic [NTMR-1:0] ticks,
  output logic            rdValid,
  output logic [DW-1:0]   rdData,
  output logic [NTMR-1:0] irqVec,
  output logic            irqAny
);
  logic [DW-1:0] rdWord [NTMR];

  for (genvar g = 0; g < NTMR; g++) begin : gTmr
    localparam logic TIDX = 1'(g);
    dtw_timer #(.DW(DW)) u_tmr (
      .clk    (clk),
      .rstN   (rstN),
      .tick   (ticks[g]),
      .wrEn   (st.tmrWr && (st.tmrIdx == TIDX)),
      .regSel (st.regSel),
      .wdata  (wdata),
      .rdWord (rdWord[g]),
      .irq    (irqVec[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= st.rdStrobe;
      if (st.rdStrobe) begin
        if (st.tmrHit)     rdData <= rdWord[st.tmrIdx];
        else if (st.idHit) rdData <= DW'(idByte(st.idIdx));
        else               rdData <= '0;
      end
    end
  end

  assign irqAny = |irqVec;

  // R8
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(st.rdStrobe));
  // R3
  id_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(st.idHit) && !$past(st.tmrHit)) |-> rdData[DW-1:8] == '0);
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import dtw_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqWdata,
  input  logic          tick0,
  input  logic          tick1,
  output logic          rdValid,
  output logic [DW-1:0] rdData,
  output logic          irq0,
  output logic          irq1,
  output logic          irqAny
);
  dtwStrobe_t      st;
  logic [NTMR-1:0] irqVec;

  dtw_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .st(st)
  );

  dtw_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wdata(reqWdata),
    .ticks({tick1, tick0}), .rdValid(rdValid), .rdData(rdData),
    .irqVec(irqVec), .irqAny(irqAny)
  );

  assign irq0 = irqVec[0];
  assign irq1 = irqVec[1];
endmodule

// File: tb/sim_dual_tick_timer.sv
`timescale 1ns/100ps
module sim_dual_tick_timer;
  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic tick0 = 1'b0, tick1 = 1'b0;
  logic rdValid, irq0, irq1, irqAny;
  logic [31:0] rdData;

  always #2.5 clk = ~clk;

  dual_tick_timer u0 (.*);

  int errors = 0, checks = 0, cycles = 0;
  string tag = "R9";
  bit done = 0;

  // model state
  int unsigned mLoad[2], mVal[2];
  bit mRun[2], mAuto[2], mIe[2], mRaw[2];
  bit expV; int unsigned expD;
  int unsigned ids[8] = '{32'h04, 32'h18, 32'h14, 32'h00, 32'h0D, 32'hF0, 32'h05, 32'hB1};

  function automatic int unsigned mRead(int unsigned a);
    int i, off;
    if (a < 32'h40) begin
      i = (a >> 5) & 1; off = (a >> 2) & 7;
      case (off)
        0: return mLoad[i];
        1: return mVal[i];
        2: return {mIe[i], mAuto[i], mRun[i]};
        4: return mRaw[i];
        5: return mRaw[i] & mIe[i];
        default: return 0;
      endcase
    end
    if (a >= 32'hFE0) return ids[(a - 32'hFE0) >> 2];
    return 0;
  endfunction

  task automatic mReset();
    for (int i = 0; i < 2; i++) begin
      mLoad[i] = 0; mVal[i] = 0; mRun[i] = 0; mAuto[i] = 0; mIe[i] = 1; mRaw[i] = 0;
    end
    expV = 0; expD = 0;
  endtask

  task automatic mStep();
    bit tk[2];
    tk[0] = tick0; tk[1] = tick1;
    expV = reqValid && !reqWrite;
    if (expV) expD = mRead(reqAddr);
    for (int i = 0; i < 2; i++) begin
      bit wr, wLd, wCt, wCl, exp0;
      int off;
      wr = reqValid && reqWrite && reqAddr < 12'h40 && ((reqAddr >> 5) & 1) == i;
      off = (reqAddr >> 2) & 7;
      wLd = wr && off == 0; wCt = wr && off == 2; wCl = wr && off == 3;
      exp0 = tk[i] && mRun[i] && mVal[i] == 0 && !wLd;
      if (wLd) begin mLoad[i] = reqWdata; mVal[i] = reqWdata; end
      else if (tk[i] && mRun[i]) begin
        if (mVal[i] == 0) begin if (mAuto[i]) mVal[i] = mLoad[i]; end
        else mVal[i] = mVal[i] - 1;
      end
      if (wCt) begin mRun[i] = reqWdata[0]; mAuto[i] = reqWdata[1]; mIe[i] = reqWdata[2]; end
      else if (exp0 && !mAuto[i]) mRun[i] = 0;
      if (exp0) mRaw[i] = 1;
      else if (wCl) mRaw[i] = 0;
    end
  endtask

  task automatic chk(string t, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  task automatic compare();
    chk({tag, " rdValid"}, rdValid, expV);   // R8
    if (expV) chk({tag, " rdData"}, rdData, expD);
    chk("R11 irq0", irq0, mRaw[0] & mIe[0]);
    chk("R11 irq1", irq1, mRaw[1] & mIe[1]);
    chk("R6 irqAny", irqAny, (mRaw[0] & mIe[0]) | (mRaw[1] & mIe[1]));
  endtask

  task automatic cyc(bit v, bit w, int unsigned a, int unsigned d);
    reqValid = v; reqWrite = w; reqAddr = a[11:0]; reqWdata = d;
    @(posedge clk);
    mStep();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(int unsigned a, int unsigned d); cyc(1, 1, a, d); endtask
  task automatic rd(int unsigned a); cyc(1, 0, a, 0); endtask
  task automatic idle(int n); for (int k = 0; k < n; k++) cyc(0, 0, 0, 0); endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<100000", cycles);
      finishRun();
    end
  end

  initial begin
    mReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R9 reset state
    tag = "R9"; compare();
    rd(12'h000); rd(12'h004); rd(12'h008); rd(12'h028);
    // R1 timer 0 registers, auto-reload counting (R10)
    tag = "R1";
    wr(12'h000, 5); rd(12'h000); rd(12'h004);
    wr(12'h008, 32'h3);   // run, auto-reload, no irq enable
    tag = "R7";
    tick0 = 1;
    for (int k = 0; k < 9; k++) rd(12'h004);
    tick0 = 0;
    rd(12'h024);          // timer 1 untouched
    tag = "R10";
    rd(12'h010); rd(12'h014); rd(12'h018); rd(12'h01C);
    wr(12'h008, 32'h7);   // enable irq: irq0 rises
    rd(12'h014);
    wr(12'h00C, 0);       // clear
    rd(12'h010);
    // R2 timer 1 one-shot
    tag = "R2";
    wr(12'h020, 2); rd(12'h020); wr(12'h028, 32'h5);
    tick1 = 1;
    for (int k = 0; k < 5; k++) rd(12'h024);
    tick1 = 0;
    rd(12'h028); rd(12'h030); rd(12'h034);
    tag = "R10";
    // expiry concurrent with clear: flag stays set
    wr(12'h028, 32'h5); tick1 = 1; wr(12'h02C, 0); tick1 = 0; rd(12'h030);
    // reload write beats tick
    tick0 = 1; wr(12'h008, 32'h1); wr(12'h000, 9); tick0 = 0; rd(12'h004);
    wr(12'h02C, 0); wr(12'h00C, 0);
    // R3 identification bytes
    tag = "R3";
    for (int k = 0; k < 8; k++) rd(32'hFE0 + 4 * k);
    // R4 test words
    tag = "R4";
    rd(12'hF00); rd(12'hF04);
    // R5 ignored writes and unmapped reads
    tag = "R5";
    wr(12'hFE0, 32'hFFFF_FFFF); wr(12'hF00, 32'hFFFF_FFFF); wr(12'hF04, 1);
    wr(12'h040, 32'h7); wr(12'h060, 32'h7); wr(12'h800, 32'h1234);
    rd(12'hFE0); rd(12'h000); rd(12'h004); rd(12'h008); rd(12'h020); rd(12'h028);
    rd(12'h040); rd(12'h060); rd(12'h800); rd(12'hF08);
    // R8 back-to-back and idle gaps
    tag = "R8";
    rd(12'h000); idle(2); rd(12'hFFC); rd(12'h004); idle(1);
    // R7 independent tick patterns with both timers running, R6 on both lines
    tag = "R7";
    wr(12'h000, 3); wr(12'h008, 32'h7); wr(12'h020, 6); wr(12'h028, 32'h7);
    for (int k = 0; k < 40; k++) begin
      tick0 = (k % 3) == 0;
      tick1 = (k % 5) != 1;
      if (k % 7 == 3) wr(12'h00C, 0);
      else if (k % 11 == 5) wr(12'h02C, 0);
      else rd((k % 2) ? 12'h024 : 12'h004);
    end
    tick0 = 0; tick1 = 0;
    idle(2);
    finishRun();
  end
endmodule